// File: doc/BRIEF.md
# Streaming Byte Pattern Detector

This block watches a byte stream, taking one byte in each clock cycle where its valid strobe is high, and reports when a fixed target string has arrived as consecutive accepted bytes. The target is a compile-time parameter: a packed byte string that ends with a zero byte, and the first zero byte sets how many characters are compared. The default target is the three characters `A`, `T`, `Z`.

A position counter records how many leading characters of the target have been seen in a row. A byte that equals the character at the current position moves the counter forward. If the byte completes the target, a one-cycle match pulse is raised and the counter goes back to zero. A byte that does not equal the expected character sends the counter back to one when that byte equals the first character of the target, and to zero otherwise. This restart rule is exact only for targets in which no character appears twice. Targets with repeated characters and full overlap handling are outside the block.

Top module: `pattern_watch`

## Requirements
- R1: After a cycle with `rst_i` high, `pos_o` is 0 and `match_o` is 0.
- R2: When an accepted byte equals the target character at index `pos_o` (index 0 is the first character) and the following character is not the zero terminator, `pos_o` becomes `pos_o + 1` after the clock edge and `match_o` stays 0.
- R3: When an accepted byte equals the target character at index `pos_o` and the following character is the zero terminator, `match_o` is 1 in the cycle after that byte and `pos_o` is 0.
- R4: `match_o` is high for exactly one cycle per completed target; with no further completing byte it is 0 in the next cycle.
- R5: An accepted byte that differs from the character at index `pos_o` but equals the first target character sets `pos_o` to 1, with `match_o` 0.
- R6: An accepted byte that differs from both the character at index `pos_o` and the first target character sets `pos_o` to 0, with `match_o` 0.
- R7: A cycle with `valid_i` low leaves `pos_o` unchanged and gives `match_o` 0, whatever `data_i` holds.
- R8: The target length is the index of the first zero byte in `PATTERN` (first character in the most significant byte); bytes after that zero have no effect, and `pos_o` is wide enough to hold length minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | High when `data_i` carries a byte to accept |
| data_i | input | 8 | Incoming byte |
| match_o | output | 1 | One-cycle pulse after the byte that completes the target |
| pos_o | output | POS_W | Count of target characters matched so far |

## Verification
The default `ATZ` target is swept exhaustively: from each reachable position, all 256 byte values are applied, which separates the advance, completion, restart-at-one and restart-at-zero outcomes and shows that only the one expected byte moves the counter forward. A long pseudo-random stream biased towards the target letters, with valid gaps mixed in, exercises broken prefixes, back-to-back completions and ignored bytes, compared cycle by cycle against an arithmetic model. A second instance with a two-character target followed by a non-zero junk byte after the terminator shows that the first zero byte alone fixes the length and the counter width.

// File: rtl/pdet_pkg.sv
package pdet_pkg;

    typedef logic [7:0] byte_t;

    // Widest pattern buffer accepted by the length search
    localparam int MAX_BYTES = 32;
    typedef logic [8*MAX_BYTES-1:0] pat_buf_t;

    // Outcome of one accepted byte
    typedef enum logic [2:0] {
        STEP_HOLD     = 3'd0,
        STEP_ADVANCE  = 3'd1,
        STEP_COMPLETE = 3'd2,
        STEP_RESTART1 = 3'd3,
        STEP_RESTART0 = 3'd4
    } step_e;

    // Byte i of a packed string of nbytes bytes, first byte in the MSBs
    function automatic byte_t pat_byte(pat_buf_t p, int nbytes, int i);
        return p[8*(nbytes-1-i) +: 8];
    endfunction

    // Index of the first zero byte; nbytes when none is present
    function automatic int term_index(pat_buf_t p, int nbytes);
        int idx;
        idx = nbytes;
        for (int i = nbytes - 1; i >= 0; i--) begin
            if (pat_byte(p, nbytes, i) == 8'h00) idx = i;
        end
        return idx;
    endfunction

    function automatic int pos_width(int len);
        return (len <= 2) ? 1 : $clog2(len);
    endfunction

endpackage

// File: rtl/pdet_char_sel.sv
module pdet_char_sel
    import pdet_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter logic [8*NBYTES-1:0] PATTERN = {"ATZ", 8'h00},
    parameter int LEN = 3,
    parameter int POS_W = 2
) (
    input  logic [POS_W-1:0] pos_i,
    output byte_t            cur_char_o,
    output byte_t            nxt_char_o,
    output byte_t            first_char_o
);
    // Characters 0..LEN, the last one being the terminator
    byte_t chars [LEN+1];

    for (genvar g = 0; g <= LEN; g++) begin : g_chars
        if (g < NBYTES) begin : g_in
            assign chars[g] = PATTERN[8*(NBYTES-1-g) +: 8];
        end else begin : g_out
            assign chars[g] = 8'h00;
        end
    end

    assign first_char_o = chars[0];

    always_comb begin
        cur_char_o = chars[0];
        nxt_char_o = chars[1];
        for (int i = 0; i < LEN; i++) begin
            if (pos_i == POS_W'(i)) begin
                cur_char_o = chars[i];
                nxt_char_o = chars[i+1];
            end
        end
    end
endmodule

// File: rtl/pdet_step.sv
module pdet_step
    import pdet_pkg::*;
#(
    parameter int POS_W = 2
) (
    input  logic             valid_i,
    input  byte_t            data_i,
    input  logic [POS_W-1:0] pos_i,
    input  byte_t            cur_char_i,
    input  byte_t            nxt_char_i,
    input  byte_t            first_char_i,
    output step_e            step_o,
    output logic [POS_W-1:0] pos_next_o,
    output logic             hit_o
);
    always_comb begin
        if (!valid_i) begin
            step_o = STEP_HOLD;
        end else if (data_i == cur_char_i) begin
            step_o = (nxt_char_i == 8'h00) ? STEP_COMPLETE : STEP_ADVANCE;
        end else if (data_i == first_char_i) begin
            step_o = STEP_RESTART1;
        end else begin
            step_o = STEP_RESTART0;
        end
    end

    always_comb begin
        hit_o = 1'b0;
        unique case (step_o)
            STEP_HOLD:     pos_next_o = pos_i;
            STEP_ADVANCE:  pos_next_o = pos_i + 1'b1;
            STEP_COMPLETE: begin
                pos_next_o = '0;
                hit_o      = 1'b1;
            end
            STEP_RESTART1: pos_next_o = POS_W'(1);
            default:       pos_next_o = '0;
        endcase
    end
endmodule

// File: rtl/pdet_state_reg.sv
module pdet_state_reg #(
    parameter int POS_W = 2,
    parameter int LEN = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             valid_i,
    input  logic [POS_W-1:0] pos_next_i,
    input  logic             hit_i,
    output logic [POS_W-1:0] pos_o,
    output logic             match_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_o   <= '0;
            match_o <= 1'b0;
        end else begin
            pos_o   <= pos_next_i;
            match_o <= hit_i;
        end
    end

    // R3
    match_zero_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        match_o |-> (pos_o == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> ($stable(pos_o) && !match_o));

    // R2
    pos_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(pos_o) < LEN);
endmodule

// File: rtl/pattern_watch.sv
module pattern_watch
    import pdet_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter logic [8*NBYTES-1:0] PATTERN = {"ATZ", 8'h00},
    localparam int LEN = term_index(pat_buf_t'(PATTERN), NBYTES),
    localparam int POS_W = pos_width(LEN)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             valid_i,
    input  logic [7:0]       data_i,
    output logic             match_o,
    output logic [POS_W-1:0] pos_o
);
    byte_t            cur_char, nxt_char, first_char;
    step_e            step;
    logic [POS_W-1:0] pos_next;
    logic             hit;

    pdet_char_sel #(
        .NBYTES(NBYTES), .PATTERN(PATTERN), .LEN(LEN), .POS_W(POS_W)
    ) u_sel (
        .pos_i(pos_o), .cur_char_o(cur_char),
        .nxt_char_o(nxt_char), .first_char_o(first_char)
    );

    pdet_step #(.POS_W(POS_W)) u_step (
        .valid_i(valid_i), .data_i(data_i), .pos_i(pos_o),
        .cur_char_i(cur_char), .nxt_char_i(nxt_char),
        .first_char_i(first_char), .step_o(step),
        .pos_next_o(pos_next), .hit_o(hit)
    );

    pdet_state_reg #(.POS_W(POS_W), .LEN(LEN)) u_reg (
        .clk_i(clk_i), .rst_i(rst_i), .valid_i(valid_i),
        .pos_next_i(pos_next), .hit_i(hit),
        .pos_o(pos_o), .match_o(match_o)
    );

    // R2
    advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && data_i == cur_char && nxt_char != 8'h00)
        |=> (pos_o == POS_W'($past(pos_o) + 1'b1)) && !match_o);

    // R3
    complete_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && data_i == cur_char && nxt_char == 8'h00) |=> match_o);

    // R5
    restart_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && data_i != cur_char && data_i == first_char)
        |=> (pos_o == POS_W'(1)) && !match_o);

    // R6
    restart_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && data_i != cur_char && data_i != first_char)
        |=> (pos_o == '0) && !match_o);
endmodule

// File: tb/tb_pattern_watch.sv
`timescale 1ns/1ps
module tb_pattern_watch;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid = 1'b0;
    logic [7:0] data = 8'h00;
    logic match;
    logic [1:0] pos;

    logic valid2 = 1'b0;
    logic [7:0] data2 = 8'h00;
    logic match2;
    logic [0:0] pos2;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state for the default target A,T,Z,0
    logic [7:0] tgt [4] = '{8'h41, 8'h54, 8'h5A, 8'h00};
    int ep = 0;
    bit em = 1'b0;

    always #2 clk = ~clk;

    pattern_watch dut (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .data_i(data),
        .match_o(match), .pos_o(pos)
    );

    // Two-character target "QK", then terminator, then a junk byte
    pattern_watch #(.NBYTES(4), .PATTERN({"QK", 8'h00, 8'h55})) dut2 (
        .clk_i(clk), .rst_i(rst), .valid_i(valid2), .data_i(data2),
        .match_o(match2), .pos_o(pos2)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(bit v, logic [7:0] b);
        em = 1'b0;
        if (v) begin
            if (b == tgt[ep]) begin
                if (tgt[ep+1] == 8'h00) begin
                    em = 1'b1;
                    ep = 0;
                end else begin
                    ep = ep + 1;
                end
            end else begin
                ep = (b == tgt[0]) ? 1 : 0;
            end
        end
    endtask

    task automatic send(bit v, logic [7:0] b, string req);
        valid = v;
        data  = b;
        model(v, b);
        @(posedge clk);
        @(negedge clk);
        check({req, " pos"}, int'(pos), ep);
        check({req, " match"}, int'(match), int'(em));
        valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ep = 0;
        em = 1'b0;
    endtask

    initial begin
        automatic logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 pos", int'(pos), 0);
        check("R1 match", int'(match), 0);
        check("R1 pos2", int'(pos2), 0);

        // Exhaustive byte sweep from every reachable position
        for (int p = 0; p < 3; p++) begin
            for (int b = 0; b < 256; b++) begin
                do_reset();
                for (int k = 0; k < p; k++) send(1'b1, tgt[k], "R2 prefix");
                // R2 R3 R5 R6: outcome classes of the swept byte
                send(1'b1, 8'(b), "R2/R3/R5/R6 sweep");
                // R4: completion pulse lasts one cycle
                send(1'b0, 8'h5A, "R4 R7 idle after");
            end
        end

        // R7: bytes without valid are ignored mid-pattern
        do_reset();
        send(1'b1, 8'h41, "R2 A");
        send(1'b0, 8'h5A, "R7 ignored Z");
        send(1'b0, 8'h41, "R7 ignored A");
        send(1'b1, 8'h54, "R2 T");
        send(1'b1, 8'h5A, "R3 Z");
        send(1'b1, 8'h41, "R4 next");

        // R5: broken prefix restarting on A
        send(1'b1, 8'h41, "R2 A");
        send(1'b1, 8'h41, "R5 AA");
        send(1'b1, 8'h54, "R2 AAT");
        send(1'b1, 8'h41, "R5 AATA");

        // Biased pseudo-random stream with valid gaps
        for (int i = 0; i < 20000; i++) begin
            logic [7:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd1: b = 8'h41;
                3'd2, 3'd3: b = 8'h54;
                3'd4, 3'd5: b = 8'h5A;
                default:    b = lfsr[15:8];
            endcase
            send(lfsr[7:3] != 5'd0, b, "R2-R7 stream");
        end

        // R8: second instance, length from first zero byte, junk after it
        begin
            logic [7:0] s2 [6] = '{8'h51, 8'h4B, 8'h51, 8'h55, 8'h51, 8'h4B};
            int ex_p [6] = '{1, 0, 1, 0, 1, 0};
            int ex_m [6] = '{0, 1, 0, 0, 0, 1};
            for (int i = 0; i < 6; i++) begin
                valid2 = 1'b1;
                data2  = s2[i];
                @(posedge clk);
                @(negedge clk);
                check("R8 pos2", int'(pos2), ex_p[i]);
                check("R8 match2", int'(match2), ex_m[i]);
                valid2 = 1'b0;
            end
            check("R8 pos width", $bits(pos2), 1);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule